// File: doc/BRIEF.md
# Interleaved ROM Wait-State Sequencer

This block paces reads from an external boot ROM. A requester presents a read with an address, a kind (cache-line fill, uncached instruction fetch or data read), a flag that says the read follows the previous one, and a stop signal. The block breaks the run into single ROM accesses. For each access it raises a start strobe, shows the wait count it chose, marks the address-decode cycle when one is paid, and pulses ready when that access's wait has counted down to zero.

The configured full wait `w` and short wait `s` (0 or 1), the bus width and the interleave setting decide the wait of each access. A ROM that is not interleaved charges `w` on every access. A 16-bit 2-way interleaved ROM follows an eight-position pattern keyed to the low three address bits. It charges a full wait at position zero, `s` at odd positions and an overlap wait at the other even positions. A run that starts between boundaries finishes the partial pattern and then starts the full pattern again at the next eight-address boundary. Fills run to a fixed length by themselves. Fetch and data runs last for as long as the requester keeps them going.

Top module: `rom_wait_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `acc_start`, `acc_decode` and `acc_rdy` are 0.
- R2: The first access of every run lasts one extra cycle, in which `acc_decode` and `acc_start` are both 1. Later accesses of the same run have no decode cycle.
- R3: A request taken while idle (`req_valid`=1, `req_stop`=0) raises `acc_start` in the next cycle. An access with wait `n` lasts `n`+1 data cycles. `acc_rdy` is 1 only in the last of them, so `n`=0 gives ready in the first data cycle. `acc_wait` and `acc_addr` stay constant for the whole access. A continuing access starts in the cycle after ready.
- R4: On a ROM that is not interleaved, every access shows wait `w`.
- R5: A fill (`req_kind`=0) on a ROM that is not interleaved makes 16 accesses when `cfg_wide`=0 and 8 when `cfg_wide`=1. The address rises by one per access.
- R6: Interleave applies when `cfg_interleave`=1 and `cfg_wide`=1. The first access of a run waits `w`. Each later access at position p = `acc_addr[2:0]` waits `w` if p=0, `s` if p is odd, and the overlap value if p is 2, 4 or 6.
- R7: An interleaved fill makes 8 accesses, and its overlap value is never below 1.
- R8: For interleaved fetch (`req_kind`=1) and data (`req_kind`=2 or 3) runs, the overlap value is never below `s`.
- R9: The overlap value is `w`-`s`-1 with saturation at 0 before the floor is applied. It never wraps.
- R10: A fetch or data run continues at each ready while `req_valid`=1, `req_seq`=1, `req_stop`=0, the kind is unchanged and the configuration is unchanged. Ready with `req_stop`=1 or `req_valid`=0 ends the run at any position.
- R11: At a ready with a request that is not sequential, or with a changed kind or configuration, a new first access starts. It has a decode cycle, wait `w` and its position taken from `req_addr`.
- R12: During a fill, `req_stop` and `req_seq` do not shorten or change the run.
- R13: With `cfg_wide`=0 the interleave setting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1: 16-bit ROM, 0: 8-bit ROM |
| cfg_interleave | input | 1 | 1: 2-way interleaved ROM |
| cfg_wait_long | input | WAIT_W | Full wait `w` |
| cfg_wait_short | input | 1 | Short wait `s` |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 fill, 1 fetch, 2/3 data |
| req_addr | input | ADDR_W | Start address of the run |
| req_seq | input | 1 | Request continues the previous access |
| req_stop | input | 1 | Requester ends the run |
| acc_start | output | 1 | First cycle of an access |
| acc_decode | output | 1 | Address-decode cycle |
| acc_addr | output | ADDR_W | Address of the current access |
| acc_wait | output | WAIT_W | Wait count of the current access |
| acc_rdy | output | 1 | Access complete |
| busy | output | 1 | A run is in progress |

## Verification
On every cycle, the assertions check the shape of each access: a single decode cycle that only a first access has, a start that follows each ready directly, wait and address held across the access, flat waits when the ROM is not interleaved, and the floors on overlap waits. Several behaviours show only in the bench's scenarios, through full wait lists and cycle counts: the lengths of fills, the realignment of a run that starts at position 5, saturation with very small `w`, a stop in the middle of the pattern, and the restart caused by a request that is not sequential or by a changed configuration.

// File: rtl/rws_pkg.sv
package rws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_WAIT   = 2'd2
    } rws_state_e;

    typedef enum logic [1:0] {
        KIND_BURST = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_DATA  = 2'd2
    } rws_kind_e;

    function automatic rws_kind_e to_kind(input logic [1:0] raw);
        case (raw)
            2'd0:    return KIND_BURST;
            2'd1:    return KIND_FETCH;
            default: return KIND_DATA;
        endcase
    endfunction

endpackage

// File: rtl/rws_wait_select.sv
module rws_wait_select #(
    parameter int WAIT_W = 4
) (
    input  logic              interleave,
    input  logic              is_burst,
    input  logic [2:0]        pos,
    input  logic [WAIT_W-1:0] w,
    input  logic              s,
    output logic [WAIT_W-1:0] wait_n
);
    localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

    logic [WAIT_W-1:0] s_ext;
    logic [WAIT_W-1:0] overlap_raw;
    logic [WAIT_W-1:0] floor_n;
    logic [WAIT_W-1:0] overlap;

    always_comb begin
        s_ext       = {{(WAIT_W-1){1'b0}}, s};
        // saturating w - s - 1
        overlap_raw = (w > s_ext) ? (w - s_ext - ONE) : '0;
        floor_n     = is_burst ? ONE : s_ext;
        overlap     = (overlap_raw < floor_n) ? floor_n : overlap_raw;
        if (!interleave)
            wait_n = w;
        else if (pos == 3'd0)
            wait_n = w;
        else if (pos[0])
            wait_n = s_ext;
        else
            wait_n = overlap;
    end

endmodule

// File: rtl/rws_wait_counter.sv
module rws_wait_counter #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              dec,
    output logic              zero
);
    logic [WAIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec && (cnt_q != '0))
            cnt_d = cnt_q - WAIT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/rom_wait_seq.sv
module rom_wait_seq
    import rws_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int WAIT_W       = 4,
    parameter int BURST_NARROW = 16,
    parameter int BURST_WIDE   = 8,
    parameter int IL_SEQ_LEN   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_interleave,
    input  logic [WAIT_W-1:0] cfg_wait_long,
    input  logic              cfg_wait_short,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_seq,
    input  logic              req_stop,
    output logic              acc_start,
    output logic              acc_decode,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [WAIT_W-1:0] acc_wait,
    output logic              acc_rdy,
    output logic              busy
);
    localparam int MAX_A    = (BURST_NARROW > BURST_WIDE) ? BURST_NARROW : BURST_WIDE;
    localparam int MAX_LEN  = (MAX_A > IL_SEQ_LEN) ? MAX_A : IL_SEQ_LEN;
    localparam int LEFT_W   = $clog2(MAX_LEN + 1);
    localparam logic [LEFT_W-1:0] LEN_NARROW = LEFT_W'(BURST_NARROW);
    localparam logic [LEFT_W-1:0] LEN_WIDE   = LEFT_W'(BURST_WIDE);
    localparam logic [LEFT_W-1:0] LEN_IL     = LEFT_W'(IL_SEQ_LEN);

    typedef struct packed {
        rws_state_e        state;
        logic              start;
        logic [ADDR_W-1:0] addr;
        logic [WAIT_W-1:0] wait_n;
        logic [LEFT_W-1:0] left;
        rws_kind_e         kind;
        logic              wide;
        logic              il;
        logic [WAIT_W-1:0] w;
        logic              s;
    } seq_t;

    seq_t r_d, r_q;
    seq_t first_r;

    logic              il_now;
    logic              cfg_same;
    logic              take_new;
    logic              cont;
    logic              ready;
    logic              cnt_zero;
    logic              cnt_load;
    logic [WAIT_W-1:0] cnt_load_val;
    logic              cnt_dec;
    logic [ADDR_W-1:0] next_addr;
    logic [WAIT_W-1:0] cont_wait;

    assign next_addr = r_q.addr + ADDR_W'(1);

    rws_wait_select #(.WAIT_W(WAIT_W)) u_sel (
        .interleave (r_q.il),
        .is_burst   (r_q.kind == KIND_BURST),
        .pos        (next_addr[2:0]),
        .w          (r_q.w),
        .s          (r_q.s),
        .wait_n     (cont_wait)
    );

    rws_wait_counter #(.WAIT_W(WAIT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    always_comb begin
        il_now   = cfg_interleave & cfg_wide;
        cfg_same = (cfg_wide == r_q.wide) && (il_now == r_q.il) &&
                   (cfg_wait_long == r_q.w) && (cfg_wait_short == r_q.s);
        take_new = req_valid && !req_stop;
        ready    = (r_q.state == ST_WAIT) && cnt_zero;
        if (r_q.kind == KIND_BURST)
            cont = (r_q.left > LEFT_W'(1)) && cfg_same;
        else
            cont = req_valid && req_seq && !req_stop &&
                   (to_kind(req_kind) == r_q.kind) && cfg_same;

        first_r        = r_q;
        first_r.state  = ST_DECODE;
        first_r.start  = 1'b1;
        first_r.addr   = req_addr;
        first_r.wait_n = cfg_wait_long;
        first_r.kind   = to_kind(req_kind);
        first_r.wide   = cfg_wide;
        first_r.il     = il_now;
        first_r.w      = cfg_wait_long;
        first_r.s      = cfg_wait_short;
        first_r.left   = il_now ? LEN_IL : (cfg_wide ? LEN_WIDE : LEN_NARROW);

        r_d          = r_q;
        r_d.start    = 1'b0;
        cnt_load     = 1'b0;
        cnt_load_val = cfg_wait_long;
        cnt_dec      = (r_q.state == ST_WAIT) && !cnt_zero;

        case (r_q.state)
            ST_IDLE: begin
                if (take_new) begin
                    r_d      = first_r;
                    cnt_load = 1'b1;
                end
            end
            ST_DECODE: begin
                r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (ready) begin
                    if (cont) begin
                        r_d.addr     = next_addr;
                        r_d.wait_n   = cont_wait;
                        r_d.left     = r_q.left - LEFT_W'(1);
                        r_d.start    = 1'b1;
                        cnt_load     = 1'b1;
                        cnt_load_val = cont_wait;
                    end else if (take_new) begin
                        r_d      = first_r;
                        cnt_load = 1'b1;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign acc_start  = r_q.start;
    assign acc_decode = (r_q.state == ST_DECODE);
    assign acc_addr   = r_q.addr;
    assign acc_wait   = r_q.wait_n;
    assign acc_rdy    = ready;
    assign busy       = (r_q.state != ST_IDLE);

    AST_DECODE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_decode |=> (!acc_decode && busy)); // R2
    AST_DECODE_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
        acc_decode |-> acc_start); // R2
    AST_CONT_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && !acc_decode) |-> $past(acc_rdy)); // R2
    AST_RDY_THEN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rdy |=> (acc_start || !busy)); // R3
    AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !acc_start) |-> ($stable(acc_wait) && $stable(acc_addr))); // R3
    AST_FIRST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_decode |-> (acc_wait == r_q.w)); // R6
    AST_NONIL_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && !r_q.il) |-> (acc_wait == r_q.w)); // R4
    AST_IL_BURST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && !acc_decode && r_q.il && (r_q.kind == KIND_BURST) &&
         !acc_addr[0] && (acc_addr[2:0] != 3'd0)) |-> (acc_wait != '0)); // R7
    AST_IL_STREAM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && !acc_decode && r_q.il && (r_q.kind != KIND_BURST) &&
         !acc_addr[0] && (acc_addr[2:0] != 3'd0)) |-> (acc_wait >= WAIT_W'(r_q.s))); // R8

endmodule

// File: tb/rom_wait_seq_tb.sv
`timescale 1ns/1ps
module rom_wait_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        cfg_interleave = 1'b0;
    logic [3:0]  cfg_wait_long = 4'd3;
    logic        cfg_wait_short = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = 16'd0;
    logic        req_seq = 1'b0;
    logic        req_stop = 1'b0;
    logic        acc_start, acc_decode, acc_rdy, busy;
    logic [15:0] acc_addr;
    logic [3:0]  acc_wait;

    always #2 clk = ~clk;

    rom_wait_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_interleave(cfg_interleave),
        .cfg_wait_long(cfg_wait_long), .cfg_wait_short(cfg_wait_short),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_seq(req_seq), .req_stop(req_stop), .acc_start(acc_start),
        .acc_decode(acc_decode), .acc_addr(acc_addr), .acc_wait(acc_wait),
        .acc_rdy(acc_rdy), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    int seen_w[$];
    int seen_a[$];
    int n_rdy = 0;
    int n_dec = 0;
    int n_busy = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_phase, m_cnt, m_addr, m_wait, m_left, m_kind, m_w, m_s;
    bit m_start, m_wide, m_il;

    function automatic int kind_of(input int raw);
        return (raw >= 2) ? 2 : raw;
    endfunction

    function automatic int ref_wait(input bit il, input bit burst, input int pos,
                                    input int w, input int s);
        int d, fl;
        if (!il || pos == 0) return w;
        if (pos % 2 == 1) return s;
        d  = w - s - 1;
        if (d < 0) d = 0;
        fl = burst ? 1 : s;
        return (d < fl) ? fl : d;
    endfunction

    task automatic ref_first();
        m_phase = 1; m_start = 1;
        m_addr  = int'(req_addr);
        m_wait  = int'(cfg_wait_long); m_cnt = m_wait;
        m_kind  = kind_of(int'(req_kind));
        m_wide  = cfg_wide; m_il = cfg_wide && cfg_interleave;
        m_w     = int'(cfg_wait_long); m_s = int'(cfg_wait_short);
        m_left  = m_il ? 8 : (cfg_wide ? 8 : 16);
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_addr = 0; m_wait = 0; m_left = 0;
            m_kind = 0; m_w = 0; m_s = 0; m_start = 0; m_wide = 0; m_il = 0;
        end else begin
            bit same, go;
            m_start = 0;
            same = (m_wide == cfg_wide) && (m_il == (cfg_wide && cfg_interleave)) &&
                   (m_w == int'(cfg_wait_long)) && (m_s == int'(cfg_wait_short));
            if (m_phase == 0) begin
                if (req_valid && !req_stop) ref_first();
            end else if (m_phase == 1) begin
                m_phase = 2;
            end else if (m_cnt > 0) begin
                m_cnt--;
            end else begin
                if (m_kind == 0) go = (m_left > 1) && same;
                else go = req_valid && req_seq && !req_stop &&
                          kind_of(int'(req_kind)) == m_kind && same;
                if (go) begin
                    m_addr  = (m_addr + 1) % 65536;
                    m_wait  = ref_wait(m_il, m_kind == 0, m_addr % 8, m_w, m_s);
                    m_cnt   = m_wait;
                    m_left--;
                    m_start = 1;
                end else if (req_valid && !req_stop) begin
                    ref_first();
                end else begin
                    m_phase = 0;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 acc_rdy", int'(acc_rdy), int'(m_phase == 2 && m_cnt == 0));
            chk("R2 acc_decode", int'(acc_decode), int'(m_phase == 1));
            chk("R3 acc_start", int'(acc_start), int'(m_start));
            chk("R10 busy", int'(busy), int'(m_phase != 0));
            if (acc_start) begin
                chk("R6 acc_wait", int'(acc_wait), m_wait);
                chk("R5 acc_addr", int'(acc_addr), m_addr);
                seen_w.push_back(int'(acc_wait));
                seen_a.push_back(int'(acc_addr));
            end
            if (acc_rdy) n_rdy++;
            if (acc_decode) n_dec++;
            if (busy) n_busy++;
        end
    end

    task automatic clear_obs();
        seen_w.delete(); seen_a.delete();
        n_rdy = 0; n_dec = 0; n_busy = 0;
    endtask

    task automatic expect_list(input string tag, input int exp[$], input bit addrs);
        chk({tag, " count"}, addrs ? seen_a.size() : seen_w.size(), exp.size());
        foreach (exp[i]) begin
            if (addrs) chk(tag, (i < seen_a.size()) ? seen_a[i] : -1, exp[i]);
            else       chk(tag, (i < seen_w.size()) ? seen_w[i] : -1, exp[i]);
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic pulse_fill(input int addr);
        @(negedge clk);
        req_valid = 1; req_kind = 2'd0; req_addr = 16'(addr); req_seq = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic finish_report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R3 actual %0d expected %0d", 1, 0);
        finish_report();
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 acc_start", int'(acc_start), 0);
        chk("R1 acc_rdy", int'(acc_rdy), 0);
        chk("R1 acc_decode", int'(acc_decode), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R5, R4, R3: 8-bit fill, w=3 -> 16 accesses, 65 busy cycles
        clear_obs();
        cfg_wide = 0; cfg_interleave = 0; cfg_wait_long = 4'd3; cfg_wait_short = 0;
        pulse_fill(16'h0100);
        wait_idle();
        expect_list("R4 narrow waits", '{3,3,3,3,3,3,3,3,3,3,3,3,3,3,3,3}, 0);
        chk("R5 narrow ready count", n_rdy, 16);
        chk("R5 narrow last addr", seen_a.size() == 16 ? seen_a[15] : -1, 16'h010F);
        chk("R3 narrow busy cycles", n_busy, 65);
        chk("R2 narrow decode cycles", n_dec, 1);

        // R5, R12: 16-bit fill with stop and seq toggled during it
        clear_obs();
        cfg_wide = 1; cfg_wait_long = 4'd2;
        pulse_fill(16'h0040);
        req_stop = 1; req_seq = 0;
        wait_idle();
        req_stop = 0; req_seq = 1;
        chk("R12 wide fill ready count", n_rdy, 8);
        chk("R5 wide fill accesses", seen_w.size(), 8);

        // R7, R9, R6: interleaved fill w=1 s=0 from position 0
        clear_obs();
        cfg_interleave = 1; cfg_wait_long = 4'd1; cfg_wait_short = 0;
        pulse_fill(16'h0000);
        wait_idle();
        expect_list("R7 il fill waits", '{1,0,1,0,1,0,1,0}, 0);

        // R6, R8, R10: interleaved data from position 5, stop after 6
        clear_obs();
        cfg_wait_long = 4'd4; cfg_wait_short = 1;
        @(negedge clk);
        req_valid = 1; req_kind = 2'd2; req_addr = 16'd5; req_seq = 1;
        k = 0;
        while (k < 6) begin
            @(negedge clk);
            if (acc_rdy) begin k++; if (k == 6) req_stop = 1; end
        end
        @(negedge clk);
        chk("R10 idle after stop", int'(busy), 0);
        req_valid = 0; req_stop = 0;
        expect_list("R6 realign waits", '{4,2,1,4,1,2}, 0);
        expect_list("R6 realign addrs", '{5,6,7,8,9,10}, 1);

        // R9, R8, R3: fetch w=0 s=1 -> overlap saturates, floored to s
        clear_obs();
        cfg_wait_long = 4'd0; cfg_wait_short = 1;
        @(negedge clk);
        req_valid = 1; req_kind = 2'd1; req_addr = 16'd0; req_seq = 1;
        k = 0;
        while (k < 4) begin
            @(negedge clk);
            if (acc_rdy) begin k++; if (k == 4) req_stop = 1; end
        end
        @(negedge clk);
        req_valid = 0; req_stop = 0;
        expect_list("R9 sat waits", '{0,1,1,1}, 0);
        chk("R3 zero-wait busy cycles", n_busy, 8);

        // R11: non-sequential request restarts with decode and full w
        clear_obs();
        cfg_wait_long = 4'd4; cfg_wait_short = 0;
        @(negedge clk);
        req_valid = 1; req_kind = 2'd2; req_addr = 16'd0; req_seq = 1;
        k = 0;
        while (k < 4) begin
            @(negedge clk);
            if (acc_rdy) begin
                k++;
                if (k == 2) begin req_seq = 0; req_addr = 16'd3; end
                if (k == 3) req_seq = 1;
                if (k == 4) req_stop = 1;
            end
        end
        @(negedge clk);
        req_valid = 0; req_stop = 0;
        expect_list("R11 restart waits", '{4,0,4,3}, 0);
        expect_list("R11 restart addrs", '{0,1,3,4}, 1);
        chk("R11 decode cycles", n_dec, 2);

        // R11: configuration change at a ready restarts the run
        clear_obs();
        @(negedge clk);
        req_valid = 1; req_kind = 2'd2; req_addr = 16'd0; req_seq = 1;
        k = 0;
        while (k < 2) begin
            @(negedge clk);
            if (acc_rdy) begin
                k++;
                if (k == 1) cfg_wait_short = 1;
                if (k == 2) req_stop = 1;
            end
        end
        @(negedge clk);
        req_valid = 0; req_stop = 0;
        expect_list("R11 cfg change waits", '{4,4}, 0);
        chk("R11 cfg change decodes", n_dec, 2);

        // R13: 8-bit ROM ignores interleave
        clear_obs();
        cfg_wide = 0; cfg_interleave = 1; cfg_wait_long = 4'd2; cfg_wait_short = 1;
        pulse_fill(16'h0003);
        wait_idle();
        chk("R13 narrow il ready count", n_rdy, 16);
        chk("R13 narrow il wait 2nd", seen_w.size() > 1 ? seen_w[1] : -1, 2);
        chk("R13 narrow il wait 3rd", seen_w.size() > 2 ? seen_w[2] : -1, 2);

        repeat (3) @(negedge clk);
        finish_report();
    end

endmodule